// File: doc/BRIEF.md
# NAND Access Width Adapter

This block sits between a CPU-side register port and a NAND flash bus belonging to one chip select. A CPU access of 1, 2 or 4 bytes that lands in one of three small windows (command, address, data) is turned into a series of device bus cycles. The device can be 8 or 16 bits wide. On writes, the CPU word is sliced low part first. On reads, the device words are gathered into one CPU result. Writes to the command window raise the command-latch enable for every cycle of the series. Writes to the address window raise the address-latch enable.

The device is a valid/ready handshake port. Each handshake moves one bus word. The device width and the device type come from the chip select's first configuration word. The type field sits at bits [11:10] and must hold code 2 (NAND). The width bit is bit 12, where 0 means 8-bit and 1 means 16-bit. While a series runs, `busy_o` is high and new requests are ignored. The CPU-side response is a one-cycle `resp_valid_o` pulse once the whole series is done.

Top module: `nand_width_adapter`

## Requirements
- R1: With the width bit at 0, a write makes 1, 2 or 4 byte cycles for size codes 0, 1 and 2 (1, 2, 4 bytes). Cycle k carries CPU byte k (bits 8k+7..8k) on `dev_wdata_o[7:0]`, with the upper byte zero.
- R2: With the width bit at 1, a 4-byte write makes two cycles, low halfword first. A 2-byte write makes one cycle. A 1-byte write also makes one cycle, and it carries the low 16 bits of the write data unchanged.
- R3: With the width bit at 0, a read makes 1, 2 or 4 cycles. The byte taken from `dev_rdata_i[7:0]` in cycle k lands in result bits 8k+7..8k. All higher result bits are zero.
- R4: With the width bit at 1, a 4-byte read places the first device word in bits 15..0 and the second in bits 31..16. A 2-byte read returns one full device word. A 1-byte read returns only bits 7..0 of one device word.
- R5: A write to the command window (offsets 0x7C to 0x7F) asserts `dev_cle_o` on every cycle. A write to the address window (0x80 to 0x83) asserts `dev_ale_o`. Data-window accesses (0x84 to 0x87) assert neither, and the two enables are never high together.
- R6: When the type field (bits [11:10]) is not 2, an access makes no device cycle. The response follows one cycle after acceptance, with read data 0.
- R7: An access outside the three windows, and a read of the command or address window, makes no device cycle. The response follows one cycle after acceptance, with data 0.
- R8: `busy_o` and `dev_valid_o` are high from the cycle after acceptance until the edge of the last handshake. They are low after reset. A request presented while busy is ignored and makes neither cycles nor a response.
- R9: `resp_valid_o` pulses for one cycle, in the cycle right after the last handshake. Write responses carry data 0.
- R10: Size code 3 behaves exactly like code 2 (4 bytes).
- R11: The byte offset inside a window has no effect. Every offset in a window behaves like the window's first offset.
- R12: While `dev_ready_i` is low, the pending cycle's data and latch enables are held steady and the series does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | CPU_W | Chip-select configuration word: type field [11:10], width bit 12 |
| req_valid_i | input | 1 | CPU access request, taken when busy_o is low |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offs_i | input | OFFS_W | Byte offset inside the chip select's register block |
| req_size_i | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata_i | input | CPU_W | Write data |
| busy_o | output | 1 | A device series is in progress |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | CPU_W | Gathered read data, valid with resp_valid_o |
| dev_valid_o | output | 1 | A device bus cycle is offered |
| dev_ready_i | input | 1 | Device accepts or returns the current word |
| dev_write_o | output | 1 | Direction of the current device cycle |
| dev_cle_o | output | 1 | Command-latch enable |
| dev_ale_o | output | 1 | Address-latch enable |
| dev_wdata_o | output | DEV_W | Device write word |
| dev_rdata_i | input | DEV_W | Device read word, sampled at the handshake |

## Verification
The bench builds the block with its default parameters: a 32-bit CPU word, a 16-bit device lane, an 8-bit offset and windows at 0x7C, 0x80 and 0x84. With these values every pairing of access size and device width is reachable, including the narrow-access rules and the reserved size code. The bench flips the width bit and the type field between accesses, so one build covers both device widths and the non-NAND path. A toggling ready signal stretches the series, which exercises the hold rules and the requests arriving while busy.

// File: rtl/nwa_pkg.sv
package nwa_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_CMD  = 2'd1,
        WIN_ADDR = 2'd2,
        WIN_DATA = 2'd3
    } nwa_win_e;

    localparam logic [1:0] NAND_TYPE_CODE = 2'd2;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // bytes moved by a CPU access of the given size code
    function automatic int unsigned nwa_bytes(logic [1:0] size);
        case (size)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

    // number of device cycles for an access
    function automatic int unsigned nwa_beats(logic wide, logic [1:0] size,
                                              int unsigned lane_bytes);
        int unsigned b;
        b = nwa_bytes(size);
        if (!wide)
            return b;
        if (b <= lane_bytes)
            return 1;
        return b / lane_bytes;
    endfunction

endpackage

// File: rtl/nwa_decode.sv
module nwa_decode
    import nwa_pkg::*;
#(
    parameter int                OFFS_W    = 8,
    parameter logic [OFFS_W-1:0] CMD_OFFS  = 'h7C,
    parameter logic [OFFS_W-1:0] ADDR_OFFS = 'h80,
    parameter logic [OFFS_W-1:0] DATA_OFFS = 'h84,
    parameter int                WIN_BYTES = 4
) (
    input  logic [OFFS_W-1:0] offs_i,
    output nwa_win_e          win_o
);

    localparam int NWIN = 3;
    localparam logic [NWIN*OFFS_W-1:0] BASES = {DATA_OFFS, ADDR_OFFS, CMD_OFFS};
    localparam logic [OFFS_W:0]        SPAN  = WIN_BYTES[OFFS_W:0];

    logic [NWIN-1:0] hit;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [OFFS_W-1:0] BASE = BASES[g*OFFS_W +: OFFS_W];
        assign hit[g] = (offs_i >= BASE) &&
                        ({1'b0, offs_i} < ({1'b0, BASE} + SPAN));
    end

    always_comb begin
        win_o = WIN_NONE;
        if (hit[0])
            win_o = WIN_CMD;
        else if (hit[1])
            win_o = WIN_ADDR;
        else if (hit[2])
            win_o = WIN_DATA;
    end

endmodule

// File: rtl/nwa_lane.sv
module nwa_lane
    import nwa_pkg::*;
#(
    parameter int CPU_W  = 32,
    parameter int DEV_W  = 16,
    parameter int BEAT_W = 3
) (
    input  logic              wide_i,
    input  logic [1:0]        size_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic [CPU_W-1:0]  wdata_i,
    input  logic [DEV_W-1:0]  rdata_i,
    output logic [DEV_W-1:0]  word_o,
    output logic [CPU_W-1:0]  placed_o
);

    localparam int NARROW_W = 8;

    int idx;

    always_comb begin
        idx = int'(beat_i);
        if (wide_i) begin
            word_o = DEV_W'(wdata_i >> (DEV_W * idx));
            if (size_i == SZ_BYTE)
                placed_o = {{(CPU_W-NARROW_W){1'b0}}, rdata_i[NARROW_W-1:0]};
            else
                placed_o = {{(CPU_W-DEV_W){1'b0}}, rdata_i} << (DEV_W * idx);
        end else begin
            word_o   = {{(DEV_W-NARROW_W){1'b0}}, NARROW_W'(wdata_i >> (NARROW_W * idx))};
            placed_o = {{(CPU_W-NARROW_W){1'b0}}, rdata_i[NARROW_W-1:0]} << (NARROW_W * idx);
        end
    end

endmodule

// File: rtl/nwa_seq.sv
module nwa_seq
    import nwa_pkg::*;
#(
    parameter int CPU_W  = 32,
    parameter int DEV_W  = 16,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  nwa_win_e          req_win_i,
    input  logic [1:0]        req_size_i,
    input  logic [CPU_W-1:0]  req_wdata_i,
    input  logic              nand_i,
    input  logic              wide_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic [1:0]        size_o,
    output logic              wide_o,
    output logic [CPU_W-1:0]  wdata_o,
    input  logic [DEV_W-1:0]  word_i,
    input  logic [CPU_W-1:0]  placed_i,
    output logic              dev_valid_o,
    input  logic              dev_ready_i,
    output logic              dev_write_o,
    output logic              dev_cle_o,
    output logic              dev_ale_o,
    output logic [DEV_W-1:0]  dev_wdata_o,
    output logic              busy_o,
    output logic              resp_valid_o,
    output logic [CPU_W-1:0]  resp_rdata_o
);

    localparam int unsigned LANE_BYTES = DEV_W / 8;

    typedef struct packed {
        logic              busy;
        logic              write;
        nwa_win_e          win;
        logic              wide;
        logic [1:0]        size;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] last;
        logic [CPU_W-1:0]  wdata;
        logic [CPU_W-1:0]  acc;
        logic              resp_valid;
        logic [CPU_W-1:0]  rdata;
    } seq_st_t;

    seq_st_t     s_d, s_q;
    logic        go;
    int unsigned n_req;
    logic [CPU_W-1:0] acc_nx;

    always_comb begin
        s_d            = s_q;
        s_d.resp_valid = 1'b0;
        go     = nand_i && ((req_win_i == WIN_DATA) ||
                            (req_write_i && (req_win_i != WIN_NONE)));
        n_req  = nwa_beats(wide_i, req_size_i, LANE_BYTES);
        acc_nx = s_q.write ? s_q.acc : (s_q.acc | placed_i);
        if (!s_q.busy) begin
            if (req_valid_i) begin
                if (go) begin
                    s_d.busy  = 1'b1;
                    s_d.write = req_write_i;
                    s_d.win   = req_win_i;
                    s_d.wide  = wide_i;
                    s_d.size  = req_size_i;
                    s_d.beat  = '0;
                    s_d.last  = BEAT_W'(n_req - 1);
                    s_d.wdata = req_wdata_i;
                    s_d.acc   = '0;
                end else begin
                    s_d.resp_valid = 1'b1;
                    s_d.rdata      = '0;
                end
            end
        end else if (dev_ready_i) begin
            if (s_q.beat == s_q.last) begin
                s_d.busy       = 1'b0;
                s_d.resp_valid = 1'b1;
                s_d.rdata      = s_q.write ? '0 : acc_nx;
            end else begin
                s_d.beat = s_q.beat + 1'b1;
                s_d.acc  = acc_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign beat_o       = s_q.beat;
    assign size_o       = s_q.size;
    assign wide_o       = s_q.wide;
    assign wdata_o      = s_q.wdata;
    assign dev_valid_o  = s_q.busy;
    assign dev_write_o  = s_q.write;
    assign dev_cle_o    = s_q.busy && (s_q.win == WIN_CMD);
    assign dev_ale_o    = s_q.busy && (s_q.win == WIN_ADDR);
    assign dev_wdata_o  = s_q.write ? word_i : '0;
    assign busy_o       = s_q.busy;
    assign resp_valid_o = s_q.resp_valid;
    assign resp_rdata_o = s_q.rdata;

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid_o && !dev_ready_i) |=> (dev_valid_o && $stable(dev_wdata_o) &&
                                          $stable(dev_cle_o) && $stable(dev_ale_o)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !(dev_ready_i && (s_q.beat == s_q.last))) |=> busy_o);

    // R9
    resp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> resp_valid_o);

    // R5
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_cle_o && dev_ale_o));

    // R5
    read_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid_o && !dev_write_o) |-> (!dev_cle_o && !dev_ale_o));

    // R1
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.beat <= s_q.last));

endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
    import nwa_pkg::*;
#(
    parameter int                CPU_W     = 32,
    parameter int                DEV_W     = 16,
    parameter int                OFFS_W    = 8,
    parameter logic [OFFS_W-1:0] CMD_OFFS  = 'h7C,
    parameter logic [OFFS_W-1:0] ADDR_OFFS = 'h80,
    parameter logic [OFFS_W-1:0] DATA_OFFS = 'h84,
    parameter int                WIN_BYTES = 4,
    parameter int                TYPE_LSB  = 10,
    parameter int                SIZE_BIT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_W-1:0]  cfg_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [OFFS_W-1:0] req_offs_i,
    input  logic [1:0]        req_size_i,
    input  logic [CPU_W-1:0]  req_wdata_i,
    output logic              busy_o,
    output logic              resp_valid_o,
    output logic [CPU_W-1:0]  resp_rdata_o,
    output logic              dev_valid_o,
    input  logic              dev_ready_i,
    output logic              dev_write_o,
    output logic              dev_cle_o,
    output logic              dev_ale_o,
    output logic [DEV_W-1:0]  dev_wdata_o,
    input  logic [DEV_W-1:0]  dev_rdata_i
);

    localparam int BEAT_W = $clog2(CPU_W / 8) + 1;

    nwa_win_e          win;
    logic              is_nand;
    logic              is_wide;
    logic              unused_cfg_bits;
    logic [BEAT_W-1:0] beat;
    logic [1:0]        lane_size;
    logic              lane_wide;
    logic [CPU_W-1:0]  lane_wdata;
    logic [DEV_W-1:0]  lane_word;
    logic [CPU_W-1:0]  lane_placed;

    assign is_nand         = (cfg_i[TYPE_LSB +: 2] == NAND_TYPE_CODE);
    assign is_wide         = cfg_i[SIZE_BIT];
    assign unused_cfg_bits = ^cfg_i;

    nwa_decode #(
        .OFFS_W   (OFFS_W),
        .CMD_OFFS (CMD_OFFS),
        .ADDR_OFFS(ADDR_OFFS),
        .DATA_OFFS(DATA_OFFS),
        .WIN_BYTES(WIN_BYTES)
    ) u_decode (
        .offs_i(req_offs_i),
        .win_o (win)
    );

    nwa_lane #(
        .CPU_W (CPU_W),
        .DEV_W (DEV_W),
        .BEAT_W(BEAT_W)
    ) u_lane (
        .wide_i  (lane_wide),
        .size_i  (lane_size),
        .beat_i  (beat),
        .wdata_i (lane_wdata),
        .rdata_i (dev_rdata_i),
        .word_o  (lane_word),
        .placed_o(lane_placed)
    );

    nwa_seq #(
        .CPU_W (CPU_W),
        .DEV_W (DEV_W),
        .BEAT_W(BEAT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_win_i   (win),
        .req_size_i  (req_size_i),
        .req_wdata_i (req_wdata_i),
        .nand_i      (is_nand),
        .wide_i      (is_wide),
        .beat_o      (beat),
        .size_o      (lane_size),
        .wide_o      (lane_wide),
        .wdata_o     (lane_wdata),
        .word_i      (lane_word),
        .placed_i    (lane_placed),
        .dev_valid_o (dev_valid_o),
        .dev_ready_i (dev_ready_i),
        .dev_write_o (dev_write_o),
        .dev_cle_o   (dev_cle_o),
        .dev_ale_o   (dev_ale_o),
        .dev_wdata_o (dev_wdata_o),
        .busy_o      (busy_o),
        .resp_valid_o(resp_valid_o),
        .resp_rdata_o(resp_rdata_o)
    );

endmodule

// File: tb/nand_width_adapter_bench.sv
`timescale 1ns/1ps
module nand_width_adapter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg = 32'h0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_offs = 8'h0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = 32'h0;
    logic        busy, resp_valid, dev_valid, dev_ready, dev_write, dev_cle, dev_ale;
    logic [31:0] resp_rdata;
    logic [15:0] dev_wdata, dev_rdata;

    always #2.5 clk = ~clk;

    nand_width_adapter u_nand_width_adapter (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_offs_i(req_offs),
        .req_size_i(req_size), .req_wdata_i(req_wdata),
        .busy_o(busy), .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata),
        .dev_valid_o(dev_valid), .dev_ready_i(dev_ready), .dev_write_o(dev_write),
        .dev_cle_o(dev_cle), .dev_ale_o(dev_ale), .dev_wdata_o(dev_wdata),
        .dev_rdata_i(dev_rdata)
    );

    int errors = 0;
    int checks = 0;

    // device model: logs every handshake, returns a pattern word per handshake
    int          hs_n = 0;
    int          resp_n = 0;
    logic        tog = 1'b0;
    logic        stall_en = 1'b0;
    logic [15:0] log_w   [256];
    logic        log_cle [256];
    logic        log_ale [256];
    logic        log_wr  [256];

    function automatic logic [15:0] pat(int k);
        return {8'(k * 5 + 49), 8'(k * 7 + 146)};
    endfunction

    assign dev_rdata = pat(hs_n);
    assign dev_ready = !stall_en || tog;

    always @(posedge clk) begin
        tog <= ~tog;
        if (dev_valid && dev_ready) begin
            log_w[hs_n % 256]   <= dev_wdata;
            log_cle[hs_n % 256] <= dev_cle;
            log_ale[hs_n % 256] <= dev_ale;
            log_wr[hs_n % 256]  <= dev_write;
            hs_n <= hs_n + 1;
        end
        if (resp_valid)
            resp_n <= resp_n + 1;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_beats(bit wide, logic [1:0] size);
        int b;
        b = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        if (wide)
            return (b <= 2) ? 1 : 2;
        return b;
    endfunction

    task automatic access(input bit wr, input logic [7:0] offs, input logic [1:0] size,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int busy_cnt, output int base, output int nhs);
        int guard;
        base = hs_n;
        busy_cnt = 0;
        guard = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_offs  = offs;
        req_size  = size;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && guard < 200) begin
            if (busy) busy_cnt++;
            @(negedge clk);
            guard++;
        end
        if (guard >= 200)
            check(1'b0, "R9 response timeout", 32'(guard), 32'd200);
        rd  = resp_rdata;
        nhs = hs_n - base;
        @(negedge clk);
    endtask

    // win: 0 data, 1 command, 2 address
    task automatic do_write(input string tag, input bit wide, input int win,
                            input logic [7:0] offs, input logic [1:0] size,
                            input logic [31:0] wd);
        logic [31:0] rd;
        int bc, base, nhs, n;
        logic [15:0] ew;
        cfg = wide ? 32'h0000_1800 : 32'h0000_0800;
        access(1'b1, offs, size, wd, rd, bc, base, nhs);
        n = exp_beats(wide, size);
        check(nhs == n, {tag, " cycle count"}, 32'(nhs), 32'(n));
        if (!stall_en)
            check(bc == n, "R8 R9 busy length", 32'(bc), 32'(n));
        check(rd == 32'h0, "R9 write response data", rd, 32'h0);
        for (int k = 0; k < n && k < nhs; k++) begin
            ew = wide ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
            check(log_w[(base + k) % 256] == ew, {tag, " beat data"},
                  32'(log_w[(base + k) % 256]), 32'(ew));
            check(log_wr[(base + k) % 256] == 1'b1, {tag, " beat direction"},
                  32'(log_wr[(base + k) % 256]), 32'd1);
            check(log_cle[(base + k) % 256] == (win == 1), "R5 command latch",
                  32'(log_cle[(base + k) % 256]), 32'(win == 1));
            check(log_ale[(base + k) % 256] == (win == 2), "R5 address latch",
                  32'(log_ale[(base + k) % 256]), 32'(win == 2));
        end
    endtask

    task automatic do_read(input string tag, input bit wide, input logic [7:0] offs,
                           input logic [1:0] size);
        logic [31:0] rd, exp;
        int bc, base, nhs, n;
        cfg = wide ? 32'h0000_1800 : 32'h0000_0800;
        access(1'b0, offs, size, 32'hFFFF_FFFF, rd, bc, base, nhs);
        n = exp_beats(wide, size);
        exp = 32'h0;
        for (int k = 0; k < n; k++) begin
            if (!wide)
                exp = exp | ({24'h0, pat(base + k)[7:0]} << (8 * k));
            else if (size == 2'd0)
                exp = {24'h0, pat(base)[7:0]};
            else
                exp = exp | ({16'h0, pat(base + k)} << (16 * k));
        end
        check(nhs == n, {tag, " cycle count"}, 32'(nhs), 32'(n));
        if (!stall_en)
            check(bc == n, "R8 R9 busy length", 32'(bc), 32'(n));
        else
            check(bc > n, "R12 stall stretches series", 32'(bc), 32'(n + 1));
        check(rd == exp, {tag, " gathered data"}, rd, exp);
        for (int k = 0; k < n && k < nhs; k++)
            check(!log_cle[(base + k) % 256] && !log_ale[(base + k) % 256],
                  "R5 data read latches", 32'(log_cle[(base + k) % 256]), 32'h0);
    endtask

    // no device cycle expected, response one cycle after acceptance
    task automatic do_silent(input string tag, input logic [31:0] c, input bit wr,
                             input logic [7:0] offs, input logic [1:0] size);
        logic [31:0] rd;
        int bc, base, nhs;
        cfg = c;
        access(wr, offs, size, 32'hA5A5_5A5A, rd, bc, base, nhs);
        check(nhs == 0, {tag, " no device cycle"}, 32'(nhs), 32'h0);
        check(bc == 0, {tag, " not busy"}, 32'(bc), 32'h0);
        check(rd == 32'h0, {tag, " response data"}, rd, 32'h0);
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R8 busy after reset", 32'(busy), 32'h0);
        check(dev_valid == 1'b0, "R8 dev_valid after reset", 32'(dev_valid), 32'h0);
        check(resp_valid == 1'b0, "R9 resp after reset", 32'(resp_valid), 32'h0);
    endtask

    task automatic t_byte_write;
        do_write("R1 word", 1'b0, 0, 8'h84, 2'd2, 32'hA1B2_C3D4);
        do_write("R1 half", 1'b0, 0, 8'h84, 2'd1, 32'h0000_5A6B);
        do_write("R1 byte", 1'b0, 0, 8'h84, 2'd0, 32'h0000_00E7);
    endtask

    task automatic t_half_write;
        do_write("R2 word", 1'b1, 0, 8'h84, 2'd2, 32'h1357_9BDF);
        do_write("R2 half", 1'b1, 0, 8'h84, 2'd1, 32'h0000_C0DE);
        do_write("R2 byte", 1'b1, 0, 8'h84, 2'd0, 32'h1234_ABCD);
    endtask

    task automatic t_windows;
        do_write("R5 command", 1'b0, 1, 8'h7C, 2'd0, 32'h0000_0070);
        do_write("R5 address", 1'b0, 2, 8'h80, 2'd2, 32'h0403_0201);
        do_write("R5 address wide", 1'b1, 2, 8'h80, 2'd1, 32'h0000_00FF);
    endtask

    task automatic t_byte_read;
        do_read("R3 word", 1'b0, 8'h84, 2'd2);
        do_read("R3 half", 1'b0, 8'h84, 2'd1);
        do_read("R3 byte", 1'b0, 8'h84, 2'd0);
    endtask

    task automatic t_half_read;
        do_read("R4 word", 1'b1, 8'h84, 2'd2);
        do_read("R4 half", 1'b1, 8'h84, 2'd1);
        do_read("R4 byte", 1'b1, 8'h84, 2'd0);
    endtask

    task automatic t_not_nand;
        do_silent("R6 type0 write", 32'h0000_0000, 1'b1, 8'h84, 2'd2);
        do_silent("R6 type3 read", 32'h0000_1C00, 1'b0, 8'h84, 2'd2);
        do_silent("R6 type1 command", 32'h0000_0400, 1'b1, 8'h7C, 2'd0);
    endtask

    task automatic t_outside;
        do_silent("R7 below windows", 32'h0000_0800, 1'b1, 8'h78, 2'd2);
        do_silent("R7 above windows", 32'h0000_0800, 1'b0, 8'h88, 2'd2);
        do_silent("R7 command read", 32'h0000_0800, 1'b0, 8'h7C, 2'd2);
        do_silent("R7 address read", 32'h0000_1800, 1'b0, 8'h81, 2'd1);
    endtask

    task automatic t_size3;
        do_write("R10 byte device", 1'b0, 0, 8'h84, 2'd3, 32'hCAFE_F00D);
        do_read("R10 wide device", 1'b1, 8'h84, 2'd3);
    endtask

    task automatic t_offset;
        do_write("R11 data inner", 1'b1, 0, 8'h86, 2'd0, 32'h0000_4321);
        do_write("R11 command inner", 1'b0, 1, 8'h7F, 2'd1, 32'h0000_3090);
        do_write("R11 address inner", 1'b1, 2, 8'h83, 2'd2, 32'hBEEF_0042);
        do_read("R11 read inner", 1'b0, 8'h87, 2'd1);
    endtask

    task automatic t_stall;
        stall_en = 1'b1;
        do_read("R12 stalled read", 1'b0, 8'h84, 2'd2);
        do_write("R12 stalled write", 1'b1, 0, 8'h84, 2'd2, 32'h8765_4321);
        stall_en = 1'b0;
    endtask

    task automatic t_busy_ignore;
        int base, r0, guard;
        stall_en = 1'b1;
        cfg = 32'h0000_1800;
        base = hs_n;
        r0 = resp_n;
        req_valid = 1'b1;
        req_write = 1'b1;
        req_offs  = 8'h84;
        req_size  = 2'd2;
        req_wdata = 32'h1111_2222;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'h1);
        req_valid = 1'b1;
        req_wdata = 32'hDEAD_BEEF;
        req_offs  = 8'h7C;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!resp_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
        stall_en = 1'b0;
        check(hs_n - base == 2, "R8 request while busy adds cycles", 32'(hs_n - base), 32'd2);
        check(resp_n - r0 == 1, "R8 request while busy adds response", 32'(resp_n - r0), 32'd1);
        check(log_w[base % 256] == 16'h2222, "R8 first word kept", 32'(log_w[base % 256]), 32'h2222);
        check(log_w[(base + 1) % 256] == 16'h1111, "R8 second word kept",
              32'(log_w[(base + 1) % 256]), 32'h1111);
        check(log_cle[(base + 1) % 256] == 1'b0, "R8 ignored command window",
              32'(log_cle[(base + 1) % 256]), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_half_write();
        t_windows();
        t_byte_read();
        t_half_read();
        t_not_nand();
        t_outside();
        t_size3();
        t_offset();
        t_stall();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule